// File: doc/BRIEF.md
# Sequential Carry-Save Shift Multiplier

This block multiplies two unsigned N-bit operands over a fixed run of 2N clock cycles using hardware that grows linearly with N. A running accumulator is held in redundant form, as a vector of sum bits plus a vector of saved carries. Each cycle adds one gated copy of the multiplicand through a single row of full adders, so the clock period is one full-adder delay for any N. No carry ever ripples across the row within a cycle.

In the first N cycles the lowest bit of the multiplier register selects whether the multiplicand enters the adder row. The accumulator and the multiplier register then shift right together, so each cycle one final low-order product bit enters the top of the multiplier register. In the next N cycles the partial-product input is held at zero and the accumulator stops shifting. Saved carries then move one column left per cycle until none remain. The product is the accumulator's sum bits above the multiplier register. A one-cycle done pulse marks it valid, and it stays on the outputs until the next operation starts.

Top module: `csmul_seq`

## Requirements
- R1: While reset is asserted and at the first cycle after its release, busy is 0, done is 0 and product is all zeros.
- R2: A start sampled high while busy is 0 loads a and b and clears the accumulator; busy is 1 in the following cycle.
- R3: done is high for exactly one cycle, 2N clock edges after the edge that accepted start. busy falls at that same edge and done is never high together with busy.
- R4: While done is high, product (2N bits, low half in bits N-1:0) equals the unsigned product a*b of the accepted operands, and every saved carry is zero.
- R5: start sampled high while busy is 1 is ignored: the running operation keeps its operands, its timing and its result.
- R6: start sampled in the cycle where done is high is accepted, so operations can follow with no idle cycle.
- R7: While busy is 0 and start is low, product holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a multiplication with the present a and b |
| a | input | N | Multiplicand, unsigned |
| b | input | N | Multiplier, unsigned |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: product is valid |
| product | output | 2N | Unsigned product, held until the next start |

## Verification
Two events can fall in the same cycle. The done pulse of one operation can meet the start of the next, and a start can arrive while the accumulate or flush steps of a running operation are underway. The bench issues each new operation in the cycle where done is high. It then checks that the scoreboard pops the older result first and that the new one arrives exactly 2N edges after its own acceptance. It also drives a start with different operands in the middle of a running operation, then checks that the pending result and its latency are unchanged and that no extra done appears.

// File: rtl/csmul_pkg.sv
package csmul_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_ACCUM = 2'd1,
      PH_FLUSH = 2'd2
   } csmul_phase_e;

endpackage

// File: rtl/csmul_csa_row.sv
module csmul_csa_row #(
   parameter int W = 32
) (
   input  logic [W-1:0] x_in,
   input  logic [W-1:0] y_in,
   input  logic [W-1:0] z_in,
   output logic [W-1:0] sum_out,
   output logic [W-1:0] cry_out
);

   generate
      if (W < 1) begin : g_bad_width
         $error("csmul_csa_row: W must be at least 1");
      end
   endgenerate

   // one independent full adder per column; cry_out[i] carries weight i+1
   for (genvar i = 0; i < W; i++) begin : g_col
      always_comb begin
         sum_out[i] = x_in[i] ^ y_in[i] ^ z_in[i];
         cry_out[i] = (x_in[i] & y_in[i]) | (z_in[i] & (x_in[i] ^ y_in[i]));
      end
   end

endmodule

// File: rtl/csmul_ctrl.sv
module csmul_ctrl
   import csmul_pkg::*;
#(
   parameter int N = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load,
   output logic step,
   output logic flush,
   output logic busy,
   output logic done
);

   localparam int CW = (N > 2) ? $clog2(N) : 1;
   localparam logic [CW-1:0] LAST = CW'(N - 1);

   csmul_phase_e ph_q;
   logic [CW-1:0] cnt_q;
   logic          done_q;

   assign busy  = (ph_q != PH_IDLE);
   assign load  = start && (ph_q == PH_IDLE);
   assign step  = busy;
   assign flush = (ph_q == PH_FLUSH);
   assign done  = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (ph_q)
            PH_IDLE: begin
               if (start) begin
                  ph_q  <= PH_ACCUM;
                  cnt_q <= '0;
               end
            end
            PH_ACCUM: begin
               if (cnt_q == LAST) begin
                  ph_q  <= PH_FLUSH;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_FLUSH: begin
               if (cnt_q == LAST) begin
                  ph_q   <= PH_IDLE;
                  cnt_q  <= '0;
                  done_q <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assert_done_not_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

endmodule

// File: rtl/csmul_datapath.sv
module csmul_datapath #(
   parameter int N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         step,
   input  logic         flush,
   input  logic         done,
   input  logic [N-1:0] a,
   input  logic [N-1:0] b,
   output logic [2*N-1:0] product
);

   logic [N-1:0] mcand_q;
   logic [N-1:0] mplr_q;
   logic [N-1:0] sum_q;
   logic [N-1:0] cry_q;

   logic [N-1:0] pp;
   logic [N-1:0] fa_sum;
   logic [N-1:0] fa_cry;
   logic [N-1:0] sum_nxt;
   logic [N-1:0] cry_nxt;
   logic [N-1:0] mplr_nxt;

   // partial product: gated multiplicand while accumulating, zero while flushing
   always_comb begin
      if (flush) pp = '0;
      else       pp = mcand_q & {N{mplr_q[0]}};
   end

   csmul_csa_row #(.W(N)) u_row (
      .x_in   (sum_q),
      .y_in   (cry_q),
      .z_in   (pp),
      .sum_out(fa_sum),
      .cry_out(fa_cry)
   );

   // accumulate: shift right, retire the column-0 sum into the multiplier register
   // flush: no shift, saved carries advance one column
   always_comb begin
      if (flush) begin
         sum_nxt  = fa_sum;
         cry_nxt  = {fa_cry[N-2:0], 1'b0};
         mplr_nxt = mplr_q;
      end else begin
         sum_nxt  = {fa_cry[N-1], fa_sum[N-1:1]};
         cry_nxt  = {1'b0, fa_cry[N-2:0]};
         mplr_nxt = {fa_sum[0], mplr_q[N-1:1]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcand_q <= '0;
         mplr_q  <= '0;
         sum_q   <= '0;
         cry_q   <= '0;
      end else if (load) begin
         mcand_q <= a;
         mplr_q  <= b;
         sum_q   <= '0;
         cry_q   <= '0;
      end else if (step) begin
         sum_q   <= sum_nxt;
         cry_q   <= cry_nxt;
         mplr_q  <= mplr_nxt;
      end
   end

   assign product = {sum_q, mplr_q};

   assert_carries_resolved_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cry_q == '0));

   assert_no_top_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && flush) |-> !fa_cry[N-1]);

   assert_operand_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> $stable(mcand_q));

   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load) |=> $stable(product));

endmodule

// File: rtl/csmul_seq.sv
module csmul_seq
   import csmul_pkg::*;
#(
   parameter int N = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [N-1:0]   a,
   input  logic [N-1:0]   b,
   output logic           busy,
   output logic           done,
   output logic [2*N-1:0] product
);

   generate
      if (N < 2) begin : g_bad_n
         $error("csmul_seq: N must be at least 2");
      end
   endgenerate

   logic load;
   logic step;
   logic flush;

   csmul_ctrl #(.N(N)) u_ctrl (
      .clk  (clk),
      .rst_n(rst_n),
      .start(start),
      .load (load),
      .step (step),
      .flush(flush),
      .busy (busy),
      .done (done)
   );

   csmul_datapath #(.N(N)) u_dp (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .step   (step),
      .flush  (flush),
      .done   (done),
      .a      (a),
      .b      (b),
      .product(product)
   );

endmodule

// File: tb/tb_csmul_seq.sv
module tb_csmul_seq;

   localparam int N = 32;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [N-1:0]   a = '0;
   logic [N-1:0]   b = '0;
   logic           busy;
   logic           done;
   logic [2*N-1:0] product;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int dones  = 0;
   bit finished = 1'b0;

   logic [2*N-1:0] exp_q[$];
   int             due_q[$];
   logic [2*N-1:0] last_exp = '0;

   always #2 clk = ~clk;

   csmul_seq #(.N(N)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .a(a), .b(b),
      .busy(busy), .done(done), .product(product)
   );

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input logic [2*N-1:0] act,
                      input logic [2*N-1:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   // monitor: pops expected result and due cycle whenever done is seen
   always @(negedge clk) begin
      if (rst_n && done) begin
         dones++;
         chk(!busy, "R3 busy low with done", {63'd0, busy}, '0);
         if (exp_q.size() == 0) begin
            chk(1'b0, "R3 unexpected done", product, '0);
         end else begin
            logic [2*N-1:0] e;
            int d;
            e = exp_q.pop_front();
            d = due_q.pop_front();
            chk(product == e, "R4 product", product, e);
            chk(cyc == d, "R3 latency", 64'(cyc), 64'(d));
            last_exp = e;
         end
      end
   end

   // driver: waits for idle (the done cycle counts, R6), issues start, pushes expectation
   task automatic issue(input logic [N-1:0] x, input logic [N-1:0] y);
      while (busy) @(negedge clk);
      start = 1'b1;
      a = x;
      b = y;
      exp_q.push_back(64'(x) * 64'(y));
      due_q.push_back(cyc + 1 + 2 * N);
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R2 busy after start", {63'd0, busy}, 64'd1);
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin : main
      int dones_before;
      repeat (3) @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0 && product == '0, "R1 reset state",
          product, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0 && product == '0, "R1 after release",
          product, '0);

      // corners, issued back to back (R6)
      issue('0, 32'h1234_5678);
      issue(32'd1, 32'hDEAD_BEEF);
      issue('1, '1);
      issue(32'h8000_0000, 32'h8000_0000);
      issue(32'h8000_0000, '1);
      issue('1, 32'd1);
      issue(32'd1, 32'd1);
      drain();
      chk(dones == 7, "R6 back-to-back count", 64'(dones), 64'd7);

      // R7: product held while idle
      repeat (6) @(negedge clk);
      chk(product == last_exp, "R7 idle hold", product, last_exp);

      // R5: start during busy is ignored
      dones_before = dones;
      issue(32'hCAFE_F00D, 32'h0BAD_1DEA);
      repeat (10) @(negedge clk);
      start = 1'b1;
      a = 32'hFFFF_0000;
      b = 32'h0000_FFFF;
      @(negedge clk);
      start = 1'b0;
      repeat (40) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      drain();
      repeat (2 * N + 4) @(negedge clk);
      chk(dones == dones_before + 1, "R5 no extra done", 64'(dones),
          64'(dones_before + 1));
      chk(product == 64'(32'hCAFE_F00D) * 64'(32'h0BAD_1DEA), "R5 result kept",
          product, 64'(32'hCAFE_F00D) * 64'(32'h0BAD_1DEA));

      // random operands (R4)
      for (int i = 0; i < 40; i++) begin
         issue($urandom, $urandom);
      end
      drain();

      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule